// File: doc/BRIEF.md
# Hardware Lock Array with Channel and CPU Owners

This block holds a set of hardware locks that command channels and the CPU use to serialise access to shared resources. Each command channel presents decoded extended commands as a one-cycle strobe together with the 32-bit command word. The CPU has its own strobe port for acquire and release. Every lock keeps an owner register. The register shows whether the lock is free, whether the CPU holds it, or whether a channel holds it and which channel that is.

A channel acquire that targets a lock held by another owner is not granted. Instead the block parks the request inside the channel port and raises that channel's stall output. The parked request is retried on every cycle until the lock becomes free. When several requesters ask for the same free lock in one cycle, a fixed-priority choice decides. A release from anyone who does not own the lock changes nothing and sets a sticky error flag. CPU acquires are not parked: the CPU polls the owner register to learn whether its request took hold.

Top module: `lock_array`

## Requirements
- R1: After reset every owner register reads zero (unlocked), no stall output is high and the error flag is low.
- R2: Each owner register is 12 bits wide. Bit 0 means a channel holds the lock and bit 1 means the CPU holds it; both bits are never set together. Bits 11:8 carry the holding channel's number, and they read zero unless a channel holds the lock. All other bits read zero.
- R3: A channel command acts only if bits 31:28 equal 0xE. Bits 27:24 select the action, 0 for acquire and 1 for release, and bits 7:0 give the lock index. An acquire of a free lock takes effect on the clock edge that samples the strobe.
- R4: A channel acquire of a lock held by another owner is not granted. The stall output of that channel is high from the following cycle, and the request is retried on every edge. The lock is granted on the first edge at which it is free, and stall is low after that edge.
- R5: When several requesters try to take the same free lock in one cycle, the CPU wins over any channel, and a lower-numbered channel wins over a higher-numbered one. The losers stall.
- R6: A release from a requester that does not own the lock, including a release of a free lock, leaves the owner register unchanged and sets the error flag. The flag stays set until reset.
- R7: A channel command with an opcode other than 0xE, or with an action code other than 0 or 1, has no effect.
- R8: A command from a channel or from the CPU whose lock index is NUM_LOCKS or above has no effect: it changes no owner, raises no stall and sets no error.
- R9: A strobe from a channel whose stall output is high is ignored.
- R10: An acquire by the current owner of a lock leaves the owner unchanged and raises no stall.
- R11: A release by the owner frees the lock on that edge. An acquire of the same lock from another channel in the same cycle stalls and is granted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | NUM_CHAN | One-cycle command strobe per channel |
| ch_cmd | input | NUM_CHAN*32 | Decoded command word per channel; channel i uses bits i*32 +: 32 |
| ch_stall | output | NUM_CHAN | High while a channel's acquire is parked |
| cpu_acq | input | 1 | CPU acquire strobe |
| cpu_rel | input | 1 | CPU release strobe; ignored when cpu_acq is also high |
| cpu_idx | input | 8 | Lock index for the CPU strobe |
| lock_owner | output | NUM_LOCKS*12 | Owner registers; lock l uses bits l*12 +: 12 |
| rel_err | output | 1 | Sticky flag for a release by a non-owner |

## Verification
The bench builds the block with NUM_LOCKS=4 and NUM_CHAN=3. With so few locks, random traffic collides on the same lock all the time, so stalls, three-way ties and owner handoffs happen often. The bench draws lock indices up to 4, so the out-of-range path is also exercised on every run. Directed sequences set up each tie, the release-and-acquire overlap and the command sent while stalled. After that, a seeded random phase compares every owner register, stall bit and the error flag with a bench model on every cycle.

// File: rtl/lockarr_pkg.sv
package lockarr_pkg;
   localparam int CMD_W  = 32;
   localparam int IDX_W  = 8;
   localparam int OWN_W  = 12;
   localparam int CHID_W = 4;
   localparam logic [3:0] OP_EXT  = 4'hE;
   localparam logic [3:0] SUB_ACQ = 4'h0;
   localparam logic [3:0] SUB_REL = 4'h1;

   typedef struct packed {
      logic [CHID_W-1:0] chid;
      logic              cpu;
      logic              ch;
   } owner_t;

   function automatic logic [OWN_W-1:0] owner_word(owner_t o);
      return {o.chid, 6'b0, o.cpu, o.ch};
   endfunction
endpackage

// File: rtl/lockarr_chan_port.sv
module lockarr_chan_port
   import lockarr_pkg::*;
#(
   parameter int NUM_LOCKS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CMD_W-1:0] cmd,
   input  logic             gnt,
   output logic             acq,
   output logic             rel,
   output logic [IDX_W-1:0] idx,
   output logic             stall
);
   localparam logic [IDX_W:0] LIM = NUM_LOCKS[IDX_W:0];

   logic             pend_q;
   logic [IDX_W-1:0] pidx_q;
   logic             new_ok;

   always_comb begin
      new_ok = req && !pend_q && (cmd[31:28] == OP_EXT) && ({1'b0, cmd[7:0]} < LIM);
      acq    = pend_q || (new_ok && cmd[27:24] == SUB_ACQ);
      rel    = new_ok && cmd[27:24] == SUB_REL;
      idx    = pend_q ? pidx_q : cmd[7:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pidx_q <= '0;
      end else begin
         pend_q <= acq && !gnt;
         if (acq) pidx_q <= idx;
      end
   end

   assign stall = pend_q;

   // R4
   pend_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(req && cmd[31:28] == OP_EXT));
endmodule

// File: rtl/lockarr_slot.sv
module lockarr_slot
   import lockarr_pkg::*;
#(
   parameter int NUM_CHAN = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_acq,
   input  logic                cpu_rel,
   input  logic [NUM_CHAN-1:0] ch_acq,
   input  logic [NUM_CHAN-1:0] ch_rel,
   output logic [NUM_CHAN-1:0] ch_gnt,
   output logic                rel_bad,
   output logic [OWN_W-1:0]    owner
);
   owner_t q, nxt;
   logic   free, found;

   always_comb begin
      free    = !q.ch && !q.cpu;
      nxt     = q;
      ch_gnt  = '0;
      rel_bad = 1'b0;
      found   = 1'b0;
      if (free) begin
         if (cpu_acq) begin
            nxt.cpu = 1'b1;
         end else begin
            for (int i = 0; i < NUM_CHAN; i++) begin
               if (ch_acq[i] && !found) begin
                  found     = 1'b1;
                  ch_gnt[i] = 1'b1;
                  nxt.ch    = 1'b1;
                  nxt.chid  = CHID_W'(i);
               end
            end
         end
      end else begin
         for (int i = 0; i < NUM_CHAN; i++)
            if (ch_acq[i] && q.ch && q.chid == CHID_W'(i)) ch_gnt[i] = 1'b1;
         if (cpu_rel && q.cpu) nxt = '0;
         for (int i = 0; i < NUM_CHAN; i++)
            if (ch_rel[i] && q.ch && q.chid == CHID_W'(i)) nxt = '0;
      end
      if (cpu_rel && !q.cpu) rel_bad = 1'b1;
      for (int i = 0; i < NUM_CHAN; i++)
         if (ch_rel[i] && !(q.ch && q.chid == CHID_W'(i))) rel_bad = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   assign owner = owner_word(q);

   // R2
   excl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(owner[0] && owner[1]));
   // R2
   chid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      owner[0] |-> (int'(owner[11:8]) < NUM_CHAN));
   // R5
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_gnt));
   // R5
   cpu_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owner[1:0] == 2'b00 && cpu_acq) |=> owner[1]);
endmodule

// File: rtl/lock_array.sv
module lock_array
   import lockarr_pkg::*;
#(
   parameter int NUM_LOCKS = 16,
   parameter int NUM_CHAN  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CHAN-1:0]       ch_req,
   input  logic [NUM_CHAN*CMD_W-1:0] ch_cmd,
   output logic [NUM_CHAN-1:0]       ch_stall,
   input  logic                      cpu_acq,
   input  logic                      cpu_rel,
   input  logic [IDX_W-1:0]          cpu_idx,
   output logic [NUM_LOCKS*OWN_W-1:0] lock_owner,
   output logic                      rel_err
);
   localparam logic [IDX_W:0] LIM = NUM_LOCKS[IDX_W:0];

   if (NUM_LOCKS < 1 || NUM_LOCKS > 256) begin : g_bad_locks
      $error("lock_array: NUM_LOCKS must be 1..256");
   end
   if (NUM_CHAN < 1 || NUM_CHAN > 16) begin : g_bad_chan
      $error("lock_array: NUM_CHAN must be 1..16");
   end

   logic [NUM_CHAN-1:0]  c_acq, c_rel, c_gnt;
   logic [IDX_W-1:0]     c_idx [NUM_CHAN];
   logic [NUM_CHAN-1:0]  gnt_mat [NUM_LOCKS];
   logic [NUM_LOCKS-1:0] bad_vec;
   logic                 cpu_in, cpu_a, cpu_r;

   for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
      lockarr_chan_port #(.NUM_LOCKS(NUM_LOCKS)) u_port (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (ch_req[i]),
         .cmd   (ch_cmd[i*CMD_W +: CMD_W]),
         .gnt   (c_gnt[i]),
         .acq   (c_acq[i]),
         .rel   (c_rel[i]),
         .idx   (c_idx[i]),
         .stall (ch_stall[i])
      );
   end

   always_comb begin
      cpu_in = {1'b0, cpu_idx} < LIM;
      cpu_a  = cpu_acq && cpu_in;
      cpu_r  = cpu_rel && !cpu_acq && cpu_in;
   end

   for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
      logic [NUM_CHAN-1:0] m_acq, m_rel;
      always_comb begin
         for (int i = 0; i < NUM_CHAN; i++) begin
            m_acq[i] = c_acq[i] && (c_idx[i] == IDX_W'(l));
            m_rel[i] = c_rel[i] && (c_idx[i] == IDX_W'(l));
         end
      end
      lockarr_slot #(.NUM_CHAN(NUM_CHAN)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .cpu_acq (cpu_a && cpu_idx == IDX_W'(l)),
         .cpu_rel (cpu_r && cpu_idx == IDX_W'(l)),
         .ch_acq  (m_acq),
         .ch_rel  (m_rel),
         .ch_gnt  (gnt_mat[l]),
         .rel_bad (bad_vec[l]),
         .owner   (lock_owner[l*OWN_W +: OWN_W])
      );
   end

   always_comb begin
      c_gnt = '0;
      for (int l = 0; l < NUM_LOCKS; l++) c_gnt = c_gnt | gnt_mat[l];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        rel_err <= 1'b0;
      else if (|bad_vec) rel_err <= 1'b1;
   end

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_err |=> rel_err);
endmodule

// File: tb/tb_lock_array.sv
module tb_lock_array;
   localparam int CLK_P = 10;
   localparam int NL = 4;
   localparam int NC = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NC-1:0]    ch_req = '0;
   logic [NC*32-1:0] ch_cmd = '0;
   logic [NC-1:0]    ch_stall;
   logic             cpu_acq = 1'b0, cpu_rel = 1'b0;
   logic [7:0]       cpu_idx = '0;
   logic [NL*12-1:0] lock_owner;
   logic             rel_err;

   lock_array #(.NUM_LOCKS(NL), .NUM_CHAN(NC)) dut (.*);

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // bench model
   bit       m_och [NL], m_ocpu [NL];
   int       m_id [NL];
   bit       m_pend [NC];
   int       m_pidx [NC];
   bit       m_err;

   function automatic logic [31:0] mk(logic [3:0] op, logic [3:0] sub, logic [7:0] idx);
      return {op, sub, 16'h0, idx};
   endfunction

   function automatic logic [11:0] exp_own(int l);
      return {(m_och[l] ? 4'(m_id[l]) : 4'h0), 6'b0, m_ocpu[l], m_och[l]};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      for (int l = 0; l < NL; l++) chk({tag, " owner"}, 32'(lock_owner[l*12 +: 12]), 32'(exp_own(l)));
      for (int i = 0; i < NC; i++) chk({tag, " stall"}, 32'(ch_stall[i]), 32'(m_pend[i]));
      chk({tag, " err"}, 32'(rel_err), 32'(m_err));
   endtask

   task automatic model_reset();
      for (int l = 0; l < NL; l++) begin m_och[l] = 0; m_ocpu[l] = 0; m_id[l] = 0; end
      for (int i = 0; i < NC; i++) begin m_pend[i] = 0; m_pidx[i] = 0; end
      m_err = 0;
   endtask

   task automatic model_step();
      bit acq [NC], rel [NC], gnt [NC];
      int idx [NC];
      bit ca, cr, och_n [NL], ocpu_n [NL];
      int id_n [NL];
      for (int i = 0; i < NC; i++) begin
         logic [31:0] c = ch_cmd[i*32 +: 32];
         bit ok = ch_req[i] && !m_pend[i] && c[31:28] == 4'hE && int'(c[7:0]) < NL;
         acq[i] = m_pend[i] || (ok && c[27:24] == 4'h0);
         rel[i] = ok && c[27:24] == 4'h1;
         idx[i] = m_pend[i] ? m_pidx[i] : int'(c[7:0]);
         gnt[i] = 0;
      end
      ca = cpu_acq && int'(cpu_idx) < NL;
      cr = cpu_rel && !cpu_acq && int'(cpu_idx) < NL;
      for (int l = 0; l < NL; l++) begin
         bit fr = !m_och[l] && !m_ocpu[l];
         bit taken = 0;
         och_n[l] = m_och[l]; ocpu_n[l] = m_ocpu[l]; id_n[l] = m_id[l];
         if (fr) begin
            if (ca && int'(cpu_idx) == l) begin ocpu_n[l] = 1; taken = 1; end
            for (int i = 0; i < NC; i++)
               if (!taken && acq[i] && idx[i] == l) begin
                  taken = 1; gnt[i] = 1; och_n[l] = 1; id_n[l] = i;
               end
         end else begin
            for (int i = 0; i < NC; i++)
               if (acq[i] && idx[i] == l && m_och[l] && m_id[l] == i) gnt[i] = 1;
            if (cr && int'(cpu_idx) == l && m_ocpu[l]) begin ocpu_n[l] = 0; id_n[l] = 0; end
            for (int i = 0; i < NC; i++)
               if (rel[i] && idx[i] == l && m_och[l] && m_id[l] == i) begin och_n[l] = 0; id_n[l] = 0; end
         end
         if (cr && int'(cpu_idx) == l && !m_ocpu[l]) m_err = 1;
         for (int i = 0; i < NC; i++)
            if (rel[i] && idx[i] == l && !(m_och[l] && m_id[l] == i)) m_err = 1;
      end
      for (int l = 0; l < NL; l++) begin m_och[l] = och_n[l]; m_ocpu[l] = ocpu_n[l]; m_id[l] = id_n[l]; end
      for (int i = 0; i < NC; i++) begin m_pend[i] = acq[i] && !gnt[i]; m_pidx[i] = idx[i]; end
   endtask

   task automatic idle();
      ch_req = '0; ch_cmd = '0; cpu_acq = 0; cpu_rel = 0; cpu_idx = '0;
   endtask

   task automatic chan(int i, logic [3:0] op, logic [3:0] sub, logic [7:0] idx);
      ch_req[i] = 1'b1;
      ch_cmd[i*32 +: 32] = mk(op, sub, idx);
   endtask

   // one clock: model advances on the same inputs, outputs sampled 1 time unit after the edge
   task automatic step();
      model_step();
      @(posedge clk);
      #1;
      idle();
   endtask

   function automatic logic [11:0] own(int l);
      return lock_owner[l*12 +: 12];
   endfunction

   task automatic do_reset();
      idle();
      rst_n = 0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1;
      model_reset();
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int unused_seed = $urandom(32'h1F2E3D);
      do_reset();
      // R1 reset state
      for (int l = 0; l < NL; l++) chk("R1 owner after reset", 32'(own(l)), 0);
      chk("R1 stall after reset", 32'(ch_stall), 0);
      chk("R1 err after reset", 32'(rel_err), 0);

      // R2 CPU takes lock 0
      cpu_acq = 1; cpu_idx = 0; step();
      chk("R2 cpu owner word", 32'(own(0)), 32'h002);

      // R3 channel 2 takes lock 1
      chan(2, 4'hE, 4'h0, 8'd1); step();
      chk("R3 ch2 owner word", 32'(own(1)), 32'h201);
      chk("R3 no stall", 32'(ch_stall[2]), 0);

      // R4 channel 1 blocked on lock 1
      chan(1, 4'hE, 4'h0, 8'd1); step();
      chk("R4 stall raised", 32'(ch_stall[1]), 1);
      chk("R4 owner kept", 32'(own(1)), 32'h201);
      step();
      chk("R4 stall held", 32'(ch_stall[1]), 1);
      // R11 release by owner while another waits
      chan(2, 4'hE, 4'h1, 8'd1); step();
      chk("R11 freed on release edge", 32'(own(1)), 0);
      chk("R11 waiter still stalled", 32'(ch_stall[1]), 1);
      step();
      chk("R4 waiter granted", 32'(own(1)), 32'h101);
      chk("R4 stall dropped", 32'(ch_stall[1]), 0);

      // R5 three-way tie on lock 2
      cpu_acq = 1; cpu_idx = 2; chan(0, 4'hE, 4'h0, 8'd2); chan(2, 4'hE, 4'h0, 8'd2); step();
      chk("R5 cpu wins", 32'(own(2)), 32'h002);
      chk("R5 losers stall", 32'(ch_stall), 32'b101);
      cpu_rel = 1; cpu_idx = 2; step();
      chk("R11 cpu release", 32'(own(2)), 0);
      step();
      chk("R5 lower channel wins", 32'(own(2)), 32'h001);
      chk("R5 ch2 still stalled", 32'(ch_stall), 32'b100);
      chan(0, 4'hE, 4'h1, 8'd2); step();
      step();
      chk("R4 ch2 granted lock 2", 32'(own(2)), 32'h201);

      // R10 owner re-acquires
      chan(1, 4'hE, 4'h0, 8'd1); step();
      chk("R10 owner kept", 32'(own(1)), 32'h101);
      chk("R10 no stall", 32'(ch_stall[1]), 0);

      // R9 strobe while stalled is ignored
      chan(2, 4'hE, 4'h0, 8'd1); step();
      chk("R9 setup stall", 32'(ch_stall[2]), 1);
      chan(2, 4'hE, 4'h1, 8'd2); step();
      chk("R9 lock 2 unchanged", 32'(own(2)), 32'h201);
      chk("R9 no error", 32'(rel_err), 0);
      chan(1, 4'hE, 4'h1, 8'd1); step();
      step();
      chk("R9 ch2 gets lock 1", 32'(own(1)), 32'h201);
      chan(2, 4'hE, 4'h1, 8'd1); step();
      chan(2, 4'hE, 4'h1, 8'd2); step();
      check_all("R11 cleanup");

      // R7 foreign opcode and unknown action
      chan(0, 4'h1, 4'h0, 8'd3); chan(1, 4'hE, 4'h2, 8'd3); step();
      chk("R7 lock 3 untouched", 32'(own(3)), 0);
      chk("R7 no stall", 32'(ch_stall), 0);
      chk("R7 no error", 32'(rel_err), 0);

      // R8 out-of-range index
      chan(0, 4'hE, 4'h0, 8'd5); chan(1, 4'hE, 4'h1, 8'd4); cpu_acq = 1; cpu_idx = 7; step();
      check_all("R8 out of range");
      chk("R8 no stall", 32'(ch_stall), 0);
      cpu_rel = 1; cpu_idx = 9; step();
      chk("R8 no error", 32'(rel_err), 0);

      // R6 non-owner release
      chan(0, 4'hE, 4'h1, 8'd0); step();
      chk("R6 owner unchanged", 32'(own(0)), 32'h002);
      chk("R6 err set", 32'(rel_err), 1);
      step();
      chk("R6 err sticky", 32'(rel_err), 1);

      // R1 reset again, then random traffic against the model
      do_reset();
      check_all("R1 second reset");
      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < NC; i++)
            if ($urandom_range(1, 0) == 1)
               chan(i, ($urandom_range(9, 0) == 0) ? 4'h3 : 4'hE,
                    4'($urandom_range(2, 0)), 8'($urandom_range(4, 0)));
         case ($urandom_range(3, 0))
            0: begin cpu_acq = 1; cpu_idx = 8'($urandom_range(4, 0)); end
            1: begin cpu_rel = 1; cpu_idx = 8'($urandom_range(4, 0)); end
            default: ;
         endcase
         step();
         check_all("R3/R4/R5/R6 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule